// File: doc/BRIEF.md
# Transfer-End Interrupt Generator

This block raises the host interrupt that marks the end of a disk data transfer. It does not watch the media for the end of a track. It combines two down-counters. The first counts host accesses to the disk controller's data register. The second is a short delay, clocked by a 1 MHz enable, that gives the controller time to finish its CRC check. The interrupt is raised only when both counters have run out.

Software uses it in a fixed order. First it writes the control port, which arms the block, clears any pending interrupt and unloads both counters. Then it writes each counter's reload value as two bytes to that counter's port, low byte first. The byte counter is normally loaded with the transfer length minus two. For example, sixteen 256-byte sectors give 0FFEh. The delay counter is loaded with 008Ch, which gives about 140 µs at 1 MHz. The delay counter starts only after the byte counter has reached zero, so the settle time follows the last byte. Either counter can be read back as two bytes through its port.

Top module: `xfer_end_irq`

## Requirements
- R1: After synchronous reset, `irq` is 0, `rdata` is 0, and both counters are unloaded with a value of 0.
- R2: Until the first control write (`sel`=2), byte writes to the counter ports (`sel`=0 byte counter, `sel`=1 delay counter) are ignored. They change neither the count nor the byte order, and read-back gives 0.
- R3: A counter takes a 16-bit reload value from two writes to its port. The first write supplies bits 7:0 and the second supplies bits 15:8. The counter becomes loaded with that value at the clock edge of the second write.
- R4: A loaded byte counter decrements by one at each clock edge where `data_access` is 1. It holds once it reaches zero, and it never counts upward except through a reload.
- R5: The delay counter decrements at each edge where `tick_1mhz` is 1, but only while the byte counter is loaded and at zero. At other times it holds its value.
- R6: `irq` rises at the first clock edge that follows a cycle in which both counters are loaded and at zero. It never rises otherwise.
- R7: Once set, `irq` stays at 1 until a control write. A control write clears `irq` at its edge, unloads both counters to 0 and resets both byte toggles to the low byte.
- R8: Each counter has one byte toggle shared by reads and writes, and every access through its port flips it. Reads return bits 7:0 when the toggle is on the low byte and bits 15:8 when it is on the high byte.
- R9: `rdata` is registered. It updates at the edge of a cycle with `rd_en`=1 and otherwise holds. Reads with `sel`=2 or `sel`=3 return 0.
- R10: Completing a new two-byte load on a counter while it is counting replaces its value at once and counting continues from the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_access | input | 1 | One-cycle strobe per host access to the controller data register |
| tick_1mhz | input | 1 | One-cycle enable at 1 MHz for the delay counter |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| sel | input | 2 | Port select: 0 byte counter, 1 delay counter, 2 control |
| wdata | input | BYTE_W | Write byte |
| rdata | output | BYTE_W | Registered read byte |
| irq | output | 1 | Transfer-end interrupt request |

## Verification
The bench builds the block with its defaults, which give 8-bit bytes and therefore 16-bit counters. At these sizes the full worked load of 0FFEh accesses followed by 008Ch delay ticks fits well within the run. The same width allows random short loads, mid-count reloads and interleaved read-backs. These exercise the shared byte toggle and the hand-off from the byte counter to the delay counter on every cycle.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int NUM_CNT = 2;
  typedef enum logic [1:0] {
    PORT_BYTES = 2'd0,
    PORT_DELAY = 2'd1,
    PORT_CTRL  = 2'd2,
    PORT_NONE  = 2'd3
  } port_sel_e;
endpackage

// File: rtl/xfer_byte_counter.sv
module xfer_byte_counter #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [BYTE_W-1:0]   wdata,
  input  logic                dec_en,
  output logic [2*BYTE_W-1:0] count_o,
  output logic [BYTE_W-1:0]   rd_byte_o,
  output logic                loaded_o
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] lo_q;
  logic              hi_sel_q;
  logic              loaded_q;
  logic              load_now;

  assign load_now = wr_en && hi_sel_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hi_sel_q <= 1'b0;
    end else if (wr_en || rd_en) begin
      hi_sel_q <= ~hi_sel_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
    end else if (wr_en && !hi_sel_q) begin
      lo_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q    <= '0;
      loaded_q <= 1'b0;
    end else if (load_now) begin
      cnt_q    <= {wdata, lo_q};
      loaded_q <= 1'b1;
    end else if (loaded_q && dec_en && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign count_o   = cnt_q;
  assign loaded_o  = loaded_q;
  assign rd_byte_o = hi_sel_q ? cnt_q[CNT_W-1:BYTE_W] : cnt_q[BYTE_W-1:0];

  // R4
  cnt_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_now && !clr) |=> (count_o <= $past(count_o)));

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (loaded_o && dec_en && (count_o != '0) && !wr_en && !clr)
      |=> (count_o == $past(count_o) - 1'b1));

  // R7
  cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!loaded_o && (count_o == '0)));
endmodule

// File: rtl/xfer_irq_latch.sv
module xfer_irq_latch (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic a_done,
  input  logic b_done,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      irq_q <= 1'b0;
    end else if (a_done && b_done) begin
      irq_q <= 1'b1;
    end
  end

  assign irq_o = irq_q;

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq_o && !(a_done && b_done)) |=> !irq_o);

  // R7
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !clr) |=> irq_o);

  // R7
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> !irq_o);
endmodule

// File: rtl/xfer_end_irq.sv
module xfer_end_irq
  import xfer_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_access,
  input  logic              tick_1mhz,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * BYTE_W;

  port_sel_e         port;
  logic              ctrl_wr;
  logic              armed_q;
  logic [BYTE_W-1:0] rdata_q;

  logic [CNT_W-1:0]  cnt_val  [NUM_CNT];
  logic [BYTE_W-1:0] cnt_byte [NUM_CNT];
  logic [NUM_CNT-1:0] cnt_ld;
  logic [NUM_CNT-1:0] cnt_done;
  logic [NUM_CNT-1:0] cnt_wr;
  logic [NUM_CNT-1:0] cnt_rd;
  logic [NUM_CNT-1:0] cnt_dec;

  assign port    = port_sel_e'(sel);
  assign ctrl_wr = wr_en && (port == PORT_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
    end else if (ctrl_wr) begin
      armed_q <= 1'b1;
    end
  end

  for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
    assign cnt_wr[gi]   = wr_en && armed_q && (sel == 2'(gi));
    assign cnt_rd[gi]   = rd_en && (sel == 2'(gi));
    assign cnt_done[gi] = cnt_ld[gi] && (cnt_val[gi] == '0);
    if (gi == 0) begin : g_first
      assign cnt_dec[gi] = data_access;
    end else begin : g_chain
      assign cnt_dec[gi] = tick_1mhz && cnt_done[gi-1];
    end

    xfer_byte_counter #(.BYTE_W(BYTE_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .clr      (ctrl_wr),
      .wr_en    (cnt_wr[gi]),
      .rd_en    (cnt_rd[gi]),
      .wdata    (wdata),
      .dec_en   (cnt_dec[gi]),
      .count_o  (cnt_val[gi]),
      .rd_byte_o(cnt_byte[gi]),
      .loaded_o (cnt_ld[gi])
    );
  end

  xfer_irq_latch u_irq (
    .clk   (clk),
    .rst   (rst),
    .clr   (ctrl_wr),
    .a_done(cnt_done[0]),
    .b_done(cnt_done[NUM_CNT-1]),
    .irq_o (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      case (port)
        PORT_BYTES: rdata_q <= cnt_byte[0];
        PORT_DELAY: rdata_q <= cnt_byte[1];
        default:    rdata_q <= '0;
      endcase
    end
  end

  assign rdata = rdata_q;

  // R2
  no_load_unarmed_chk: assert property (@(posedge clk) disable iff (rst)
    (!armed_q && !ctrl_wr) |=> (cnt_ld == '0));

  // R5
  delay_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (!cnt_done[0] && !cnt_wr[1] && !ctrl_wr) |=> $stable(cnt_val[1]));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/sim_xfer_end_irq.sv
module sim_xfer_end_irq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       data_access = 1'b0;
  logic       tick_1mhz = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // model state, derived from the requirements
  logic        m_arm;
  logic        m_irq;
  logic [7:0]  m_rdata;
  logic [15:0] m_cnt [2];
  logic [7:0]  m_lo  [2];
  logic        m_tg  [2];
  logic        m_ld  [2];

  always #2.5 clk = ~clk;

  xfer_end_irq u0 (
    .clk(clk), .rst(rst), .data_access(data_access), .tick_1mhz(tick_1mhz),
    .wr_en(wr_en), .rd_en(rd_en), .sel(sel), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_arm = 0; m_irq = 0; m_rdata = 0;
    for (int i = 0; i < 2; i++) begin
      m_cnt[i] = 0; m_lo[i] = 0; m_tg[i] = 0; m_ld[i] = 0;
    end
  endtask

  task automatic model_edge(input logic acc, tk, wr, rd,
                            input logic [1:0] s, input logic [7:0] d);
    logic a_done, b_done, en;
    logic [15:0] pre_cnt [2];
    a_done = m_ld[0] && (m_cnt[0] == 0);
    b_done = m_ld[1] && (m_cnt[1] == 0);
    pre_cnt[0] = m_cnt[0];
    pre_cnt[1] = m_cnt[1];
    if (rd) begin
      if (s < 2) m_rdata = m_tg[s[0]] ? pre_cnt[s[0]][15:8] : pre_cnt[s[0]][7:0];
      else m_rdata = 8'h00;
    end
    if (wr && s == 2'd2) begin
      m_arm = 1; m_irq = 0;
      for (int i = 0; i < 2; i++) begin
        m_cnt[i] = 0; m_tg[i] = 0; m_ld[i] = 0;
      end
    end else begin
      if (a_done && b_done) m_irq = 1;
      for (int i = 0; i < 2; i++) begin
        en = (i == 0) ? acc : (tk && a_done);
        if (wr && s == 2'(i) && m_arm) begin
          if (!m_tg[i]) m_lo[i] = d;
          else begin m_cnt[i] = {d, m_lo[i]}; m_ld[i] = 1; end
          m_tg[i] = ~m_tg[i];
        end else begin
          if (m_ld[i] && en && m_cnt[i] != 0) m_cnt[i] = m_cnt[i] - 1;
          if (rd && s == 2'(i)) m_tg[i] = ~m_tg[i];
        end
      end
    end
  endtask

  // called at a negedge; drives one cycle, then compares at the next negedge
  task automatic step(input string tag, input logic acc, tk, wr, rd,
                      input logic [1:0] s, input logic [7:0] d);
    data_access = acc; tick_1mhz = tk; wr_en = wr; rd_en = rd; sel = s; wdata = d;
    @(posedge clk);
    #1;
    model_edge(acc, tk, wr, rd, s, d);
    @(negedge clk);
    check(tag, "irq", {15'd0, irq}, {15'd0, m_irq});
    check(tag, "rdata", {8'd0, rdata}, {8'd0, m_rdata});
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, 0, 2'd3, 8'h00);
  endtask

  task automatic wr_byte(input string tag, input logic [1:0] s, input logic [7:0] d);
    step(tag, 0, 0, 1, 0, s, d);
  endtask

  task automatic rd_byte(input string tag, input logic [1:0] s);
    step(tag, 0, 0, 0, 1, s, 8'h00);
  endtask

  task automatic load16(input string tag, input logic [1:0] s, input logic [15:0] v);
    wr_byte(tag, s, v[7:0]);
    wr_byte(tag, s, v[15:8]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed_0042);
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1", "irq", {15'd0, irq}, 16'd0);
    check("R1", "rdata", {8'd0, rdata}, 16'd0);
    rd_byte("R1", 2'd0);
    check("R1", "count lo", {8'd0, rdata}, 16'd0);

    // R2: writes before arming are ignored
    wr_byte("R2", 2'd0, 8'h34);
    wr_byte("R2", 2'd0, 8'h12);
    wr_byte("R2", 2'd1, 8'h01);
    rd_byte("R2", 2'd0);
    check("R2", "unarmed hi", {8'd0, rdata}, 16'd0);
    step("R2", 1, 1, 0, 0, 2'd3, 8'h00);
    check("R2", "no irq", {15'd0, irq}, 16'd0);

    // arm, R3 load and R8 read-back order
    wr_byte("R7", 2'd2, 8'h00);
    load16("R3", 2'd0, 16'h1234);
    rd_byte("R8", 2'd0);
    check("R8", "lo first", {8'd0, rdata}, 16'h0034);
    rd_byte("R8", 2'd0);
    check("R8", "hi second", {8'd0, rdata}, 16'h0012);
    // R4 three accesses
    repeat (3) step("R4", 1, 0, 0, 0, 2'd3, 8'h00);
    rd_byte("R4", 2'd0);
    check("R4", "dec lo", {8'd0, rdata}, 16'h0031);
    rd_byte("R4", 2'd0);
    // R9 control read gives 0
    rd_byte("R9", 2'd2);
    check("R9", "ctrl read", {8'd0, rdata}, 16'd0);
    idle("R9");
    check("R9", "hold", {8'd0, rdata}, 16'd0);

    // worked example: 0FFEh accesses then 008Ch ticks
    wr_byte("R7", 2'd2, 8'h00);
    load16("R3", 2'd0, 16'h0FFE);
    load16("R3", 2'd1, 16'h008C);
    // R5: ticks before byte count ends do nothing
    repeat (5) step("R5", 0, 1, 0, 0, 2'd3, 8'h00);
    rd_byte("R5", 2'd1);
    check("R5", "delay held", {8'd0, rdata}, 16'h008C);
    rd_byte("R5", 2'd1);
    repeat (16'h0FFE) step("R4", 1, 0, 0, 0, 2'd3, 8'h00);
    check("R6", "no irq before delay", {15'd0, irq}, 16'd0);
    repeat (16'h008B) step("R5", 0, 1, 0, 0, 2'd3, 8'h00);
    check("R6", "one tick left", {15'd0, irq}, 16'd0);
    step("R5", 0, 1, 0, 0, 2'd3, 8'h00);
    idle("R6");
    check("R6", "irq up", {15'd0, irq}, 16'd1);
    repeat (10) step("R7", 1, 1, 0, 0, 2'd3, 8'h00);
    check("R7", "sticky", {15'd0, irq}, 16'd1);
    wr_byte("R7", 2'd2, 8'h00);
    check("R7", "cleared", {15'd0, irq}, 16'd0);
    rd_byte("R7", 2'd0);
    check("R7", "unloaded", {8'd0, rdata}, 16'd0);

    // R10 reload mid-count
    wr_byte("R7", 2'd2, 8'h00);
    load16("R10", 2'd0, 16'h0020);
    load16("R10", 2'd1, 16'h0000);
    repeat (10) step("R10", 1, 0, 0, 0, 2'd3, 8'h00);
    load16("R10", 2'd0, 16'h0005);
    repeat (4) step("R10", 1, 0, 0, 0, 2'd3, 8'h00);
    check("R10", "not yet", {15'd0, irq}, 16'd0);
    step("R10", 1, 0, 0, 0, 2'd3, 8'h00);
    idle("R10");
    check("R10", "irq after reload", {15'd0, irq}, 16'd1);

    // random transfers
    for (int r = 0; r < 40; r++) begin
      logic [15:0] na, nb;
      na = 16'($urandom_range(0, 60));
      nb = 16'($urandom_range(0, 30));
      wr_byte("R7", 2'd2, 8'h00);
      load16("R3", 2'd0, na);
      load16("R3", 2'd1, nb);
      for (int c = 0; c < 500; c++) begin
        int unsigned k;
        k = $urandom_range(0, 9);
        if (k == 0) rd_byte("R8", 2'($urandom_range(0, 3)));
        else step("R6", 1'($urandom_range(0, 1)), ($urandom_range(0, 2) == 0),
                  0, 0, 2'd3, 8'h00);
        if (m_irq && c > 100) break;
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule